// File: doc/BRIEF.md
# Coarse/Fine Delay-Locked-Loop Control Core

This block is the digital heart of a register-controlled delay-locked loop. A phase detector supplies one early/late decision per cycle on `pd_up`. The block samples that decision only on a periodic update tick. It keeps the whole delay setting in registers and drives three control words to the analog side:

- a tap index for delay line A;
- a tap index for delay line B;
- a fine weight for the phase mixer, which blends the outputs of the two lines.

The two lines are interleaved so that their delays always differ by exactly one unit cell. Line A realises `2*coarse_a` units. Line B realises `2*coarse_b+1` units. The mixer output is `A*(15-fine_k)/15 + B*fine_k/15`.

When the fine weight has reached the end that selects the longer line, a further "up" decision does not change the weight. Instead it moves the idle, shorter line two units along, so that it becomes the longer one. Later decisions then walk the weight back across. Because the line being moved carries no weight at that moment, no glitch reaches the output. A coarse move and a fine change never share an update.

Lock is declared once the decisions start dithering, which means the loop delay sits at a whole number of clock periods. A budget timer flags a loop that fails to lock soon enough after enable.

The controller is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Disabled. |
| `ST_ARM` | Enabled, waiting for the first tick. |
| `ST_TRACK` | Stepping on each tick, not yet locked. |
| `ST_LOCKED` | Stepping on each tick, lock asserted. |

Transitions:

| From | To | Condition |
|---|---|---|
| any state | `ST_IDLE` | `enable` low |
| `ST_IDLE` | `ST_ARM` | `enable` high |
| `ST_ARM` | `ST_TRACK` | first tick; codes are loaded |
| `ST_TRACK` | `ST_LOCKED` | a tick completes an alternating run of `LOCK_RUN` decisions |
| `ST_LOCKED` | `ST_TRACK` | a tick repeats the previous decision |

Top module: `dll_delay_ctrl`

## Requirements
- R1: While `enable` is high, `upd_tick` is high for one cycle in every `UPD_PERIOD` cycles (default 2). Control words change only on the clock edge that ends a cycle in which `upd_tick` is high, and each such tick applies at most one step.
- R2: The first tick after `enable` rises loads `coarse_a=0`, `coarse_b=0` and `fine_k=0`, and clears `range_err`, whatever the value of `pd_up`.
- R3: Delay encoding: line A is `2*coarse_a` units, line B is `2*coarse_b+1` units, and the mixer weight on B is `fine_k/15`. On a later tick with `pd_up=1`, if the weight is not yet fully on the longer line, `fine_k` moves by one toward that line. This raises the mixed delay by exactly 1/15 unit. B is the longer line when `coarse_b >= coarse_a`.
- R4: On an up tick where the weight already sits fully on the longer line, the shorter line's index rises by one and `fine_k` is unchanged. Across all updates, the two indices always satisfy `coarse_b == coarse_a` or `coarse_b == coarse_a-1`. No update changes a coarse index and `fine_k` together.
- R5: On a tick with `pd_up=0`, the weight moves one step toward the shorter line. If the weight already sits fully on the shorter line, the longer line's index falls by one and `fine_k` is unchanged.
- R6: A coarse move that would take an index below 0 or above `2**CW-1` is not made. That tick leaves every code unchanged and sets `range_err`. The next tick that applies a step clears `range_err`.
- R7: `lock` rises on the tick that completes `LOCK_RUN` (4) consecutive ticks whose decisions alternate. It stays high while the decisions keep alternating, and falls on a tick whose decision repeats the previous one.
- R8: `lock_timeout` rises exactly `LOCK_BUDGET` (200) clock edges after `enable` rises if `lock` has not been seen in that time. It never rises once `lock` has been seen, and it clears when `enable` falls.
- R9: With `enable` low, `lock` is low, `upd_tick` is low, and the control words hold their values regardless of `pd_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the loop; low returns it to idle |
| pd_up | input | 1 | Phase detector decision: 1 = add delay, 0 = remove delay |
| upd_tick | output | 1 | Periodic update strobe |
| coarse_a | output | CW | Tap index of delay line A |
| coarse_b | output | CW | Tap index of delay line B |
| fine_k | output | FW | Mixer weight on line B, in fifteenths |
| lock | output | 1 | Loop is locked |
| range_err | output | 1 | Last attempted coarse move was out of range |
| lock_timeout | output | 1 | No lock within the cycle budget |

## Verification
The bench drives a steady run of "up" decisions across two full coarse boundaries and checks the mixed delay after every tick. That delay must grow by exactly one fine step, or stay level while only the idle line moves, which separates correct interleaving from a swap, double step or fine reset. A short run of "down" decisions crosses one boundary in the reverse direction. Alternating patterns, with a repeat placed before and after the fourth alternation, tell a correct run length from an off-by-one lock and show the drop on a repeated decision. Decisions that press against index 0 and index 63 tell saturation apart from wrap-around, and a constant pattern that never dithers exercises the 200-cycle budget at the exact boundary edge.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_TRACK  = 2'd2,
        ST_LOCKED = 2'd3
    } dll_state_t;

endpackage

// File: rtl/dll_upd_timer.sv
module dll_upd_timer #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int CNTW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(PERIOD - 1);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNTW'(1);
        end
    end

    assign tick = enable && (cnt_q == LAST);

endmodule

// File: rtl/dll_code_step.sv
module dll_code_step #(
    parameter int CW = 6,
    parameter int FW = 4
) (
    input  logic [CW-1:0] ca,
    input  logic [CW-1:0] cb,
    input  logic [FW-1:0] k,
    input  logic          up,
    output logic [CW-1:0] ca_n,
    output logic [CW-1:0] cb_n,
    output logic [FW-1:0] k_n,
    output logic          blocked
);
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [FW-1:0] KMAX = '1;

    logic long_b;
    logic on_long;
    logic on_short;

    always_comb begin
        long_b   = (cb >= ca);
        on_long  = long_b ? (k == KMAX) : (k == '0);
        on_short = long_b ? (k == '0)   : (k == KMAX);
        ca_n     = ca;
        cb_n     = cb;
        k_n      = k;
        blocked  = 1'b0;
        if (up) begin
            if (!on_long) begin
                k_n = long_b ? (k + FW'(1)) : (k - FW'(1));
            end else if (long_b) begin
                if (ca == CMAX) blocked = 1'b1;
                else            ca_n = ca + CW'(1);
            end else begin
                if (cb == CMAX) blocked = 1'b1;
                else            cb_n = cb + CW'(1);
            end
        end else begin
            if (!on_short) begin
                k_n = long_b ? (k - FW'(1)) : (k + FW'(1));
            end else if (long_b) begin
                if (cb == '0) blocked = 1'b1;
                else          cb_n = cb - CW'(1);
            end else begin
                if (ca == '0) blocked = 1'b1;
                else          ca_n = ca - CW'(1);
            end
        end
    end

endmodule

// File: rtl/dll_lock_budget.sv
module dll_lock_budget #(
    parameter int BUDGET = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic locked,
    output logic timeout
);
    localparam int BW = $clog2(BUDGET + 1);
    localparam logic [BW-1:0] LAST = BW'(BUDGET - 1);

    logic [BW-1:0] cnt_q;
    logic          seen_q;
    logic          to_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
            to_q   <= 1'b0;
        end else if (!enable) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            if (locked) seen_q <= 1'b1;
            if (!seen_q && !locked && !to_q) begin
                if (cnt_q == LAST) to_q <= 1'b1;
                else               cnt_q <= cnt_q + BW'(1);
            end
        end
    end

    assign timeout = to_q;

endmodule

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl
    import dll_ctrl_pkg::*;
#(
    parameter int CW          = 6,
    parameter int FW          = 4,
    parameter int UPD_PERIOD  = 2,
    parameter int LOCK_RUN    = 4,
    parameter int LOCK_BUDGET = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          pd_up,
    output logic          upd_tick,
    output logic [CW-1:0] coarse_a,
    output logic [CW-1:0] coarse_b,
    output logic [FW-1:0] fine_k,
    output logic          lock,
    output logic          range_err,
    output logic          lock_timeout
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);

    dll_state_t    state_q, state_d;
    logic [CW-1:0] ca_q, cb_q, ca_s, cb_s;
    logic [FW-1:0] k_q, k_s;
    logic          blocked_s;
    logic [RW-1:0] run_q, run_d;
    logic          prev_q;
    logic          rerr_q;
    logic          tick;
    logic          run_done;

    dll_upd_timer #(.PERIOD(UPD_PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (tick)
    );

    dll_code_step #(.CW(CW), .FW(FW)) u_step (
        .ca      (ca_q),
        .cb      (cb_q),
        .k       (k_q),
        .up      (pd_up),
        .ca_n    (ca_s),
        .cb_n    (cb_s),
        .k_n     (k_s),
        .blocked (blocked_s)
    );

    dll_lock_budget #(.BUDGET(LOCK_BUDGET)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .locked  (lock),
        .timeout (lock_timeout)
    );

    // Length of the current run of alternating decisions, saturating.
    always_comb begin
        if (run_q == '0)            run_d = RW'(1);
        else if (pd_up != prev_q)   run_d = (run_q == RUN_MAX) ? run_q : run_q + RW'(1);
        else                        run_d = RW'(1);
        run_done = (run_d == RUN_MAX);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_ARM;
                ST_ARM:    if (tick) state_d = ST_TRACK;
                ST_TRACK:  if (tick && run_done) state_d = ST_LOCKED;
                ST_LOCKED: if (tick && !run_done) state_d = ST_TRACK;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: control words, run tracking, range flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca_q   <= '0;
            cb_q   <= '0;
            k_q    <= '0;
            run_q  <= '0;
            prev_q <= 1'b0;
            rerr_q <= 1'b0;
        end else if (enable && tick) begin
            case (state_q)
                ST_ARM: begin
                    ca_q   <= '0;
                    cb_q   <= '0;
                    k_q    <= '0;
                    run_q  <= '0;
                    rerr_q <= 1'b0;
                end
                ST_TRACK, ST_LOCKED: begin
                    if (blocked_s) begin
                        rerr_q <= 1'b1;
                    end else begin
                        ca_q   <= ca_s;
                        cb_q   <= cb_s;
                        k_q    <= k_s;
                        rerr_q <= 1'b0;
                    end
                    run_q  <= run_d;
                    prev_q <= pd_up;
                end
                default: ;
            endcase
        end
    end

    assign upd_tick  = tick;
    assign coarse_a  = ca_q;
    assign coarse_b  = cb_q;
    assign fine_k    = k_q;
    assign range_err = rerr_q;
    assign lock      = (state_q == ST_LOCKED);

endmodule

// File: rtl/dll_delay_ctrl_chk.sv
module dll_delay_ctrl_chk #(
    parameter int CW = 6,
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          upd_tick,
    input logic [CW-1:0] coarse_a,
    input logic [CW-1:0] coarse_b,
    input logic [FW-1:0] fine_k,
    input logic          lock,
    input logic          range_err
);
    // Set after the first tick of an enabled session: later ticks are steps.
    logic tracking;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tracking <= 1'b0;
        else if (!enable)  tracking <= 1'b0;
        else if (upd_tick) tracking <= 1'b1;
    end

    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_tick) |-> ($stable(coarse_a) && $stable(coarse_b) && $stable(fine_k)));

    p_first_tick_loads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_tick) && $past(enable) && !$past(tracking))
        |-> (coarse_a == '0 && coarse_b == '0 && fine_k == '0));

    p_fine_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tracking) |->
        ({1'b0, fine_k} == {1'b0, $past(fine_k)} ||
         {1'b0, fine_k} == {1'b0, $past(fine_k)} + 1'b1 ||
         {1'b0, fine_k} + 1'b1 == {1'b0, $past(fine_k)}));

    p_lines_one_unit_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_b == coarse_a) || ({1'b0, coarse_b} + 1'b1 == {1'b0, coarse_a}));

    p_no_coarse_with_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_tick) && $past(tracking) && !($stable(coarse_a) && $stable(coarse_b)))
        |-> $stable(fine_k));

    p_blocked_holds_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(range_err) |-> ($stable(coarse_a) && $stable(coarse_b) && $stable(fine_k)));

    p_no_lock_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !lock);

endmodule

bind dll_delay_ctrl dll_delay_ctrl_chk #(.CW(CW), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .upd_tick  (upd_tick),
    .coarse_a  (coarse_a),
    .coarse_b  (coarse_b),
    .fine_k    (fine_k),
    .lock      (lock),
    .range_err (range_err)
);

// File: tb/dll_delay_ctrl_tb.sv
module dll_delay_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 6;
    localparam int FW = 4;
    localparam int UPD_PERIOD = 2;
    localparam int LOCK_BUDGET = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          pd_up = 1'b0;
    logic          upd_tick;
    logic [CW-1:0] coarse_a, coarse_b;
    logic [FW-1:0] fine_k;
    logic          lock, range_err, lock_timeout;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_delay_ctrl #(.CW(CW), .FW(FW), .UPD_PERIOD(UPD_PERIOD),
                     .LOCK_RUN(4), .LOCK_BUDGET(LOCK_BUDGET)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pd_up(pd_up),
        .upd_tick(upd_tick), .coarse_a(coarse_a), .coarse_b(coarse_b),
        .fine_k(fine_k), .lock(lock), .range_err(range_err),
        .lock_timeout(lock_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_codes(input string tag, input int a, input int b, input int k);
        chk({tag, " coarse_a"}, int'(coarse_a), a);
        chk({tag, " coarse_b"}, int'(coarse_b), b);
        chk({tag, " fine_k"},   int'(fine_k),   k);
    endtask

    // Mixed delay in fifteenths of a unit cell.
    function automatic int mix_delay();
        return 2*int'(coarse_a)*(15 - int'(fine_k)) + (2*int'(coarse_b) + 1)*int'(fine_k);
    endfunction

    // Present a decision and return at the falling edge after it is applied.
    task automatic step(input logic up);
        pd_up = up;
        while (upd_tick !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; enable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_codes("R2 reset", 0, 0, 0);
        chk("R9 reset lock", int'(lock), 0);
        chk("R9 reset tick", int'(upd_tick), 0);
        chk("R6 reset range_err", int'(range_err), 0);
        chk("R8 reset timeout", int'(lock_timeout), 0);
    endtask

    task automatic t_init_ignores_pd;
        enable = 1'b1;
        step(1'b0);
        chk_codes("R2 first tick", 0, 0, 0);
        chk("R2 first tick range_err", int'(range_err), 0);
    endtask

    task automatic t_low_saturation;
        step(1'b0);
        chk("R6 low blocked flag", int'(range_err), 1);
        chk_codes("R6 low blocked codes", 0, 0, 0);
        step(1'b1);
        chk("R6 flag cleared", int'(range_err), 0);
        chk_codes("R3 first up", 0, 0, 1);
    endtask

    task automatic t_tick_period;
        int n;
        int k0;
        pd_up = 1'b1;
        while (upd_tick !== 1'b1) @(negedge clk);
        k0 = int'(fine_k);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (upd_tick !== 1'b1);
        chk("R1 tick spacing", n, UPD_PERIOD);
        chk("R1 one step per tick", int'(fine_k), k0 + 1);
        @(negedge clk);
        chk("R1 second tick applied", int'(fine_k), k0 + 2);
    endtask

    task automatic t_up_walk;
        for (int i = 0; i < 30; i++) begin
            int d0, a0, b0, k0, d1;
            bit ok;
            d0 = mix_delay(); a0 = int'(coarse_a); b0 = int'(coarse_b); k0 = int'(fine_k);
            step(1'b1);
            d1 = mix_delay();
            ok = ((d1 == d0 + 1) && a0 == int'(coarse_a) && b0 == int'(coarse_b)) ||
                 ((d1 == d0) && k0 == int'(fine_k) &&
                  (a0 != int'(coarse_a) || b0 != int'(coarse_b)));
            chk("R3/R4 up step delay", int'(ok), 1);
            if (i == 11) chk_codes("R3 weight full on B", 0, 0, 15);
            if (i == 12) chk_codes("R4 idle A shifted", 1, 0, 15);
            if (i == 27) chk_codes("R3 weight full on A", 1, 0, 0);
            if (i == 28) chk_codes("R4 idle B shifted", 1, 1, 0);
        end
        chk_codes("R3 after walk", 1, 1, 1);
    endtask

    task automatic t_down_walk;
        int d0;
        d0 = mix_delay();
        step(1'b0);
        chk_codes("R5 down toward A", 1, 1, 0);
        chk("R5 delay fell", mix_delay(), d0 - 1);
        step(1'b0);
        chk_codes("R5 long B lowered", 1, 0, 0);
        chk("R5 delay level on shift", mix_delay(), d0 - 1);
        step(1'b0);
        chk_codes("R5 down toward B", 1, 0, 1);
        chk("R5 delay fell again", mix_delay(), d0 - 2);
    endtask

    task automatic t_disable;
        int a0, b0, k0;
        enable = 1'b0;
        @(negedge clk);
        a0 = int'(coarse_a); b0 = int'(coarse_b); k0 = int'(fine_k);
        for (int i = 0; i < 8; i++) begin
            pd_up = i[0];
            @(negedge clk);
        end
        chk_codes("R9 codes held", a0, b0, k0);
        chk("R9 lock low", int'(lock), 0);
        chk("R9 tick low", int'(upd_tick), 0);
        chk("R8 timeout cleared", int'(lock_timeout), 0);
    endtask

    task automatic t_timeout;
        pd_up = 1'b1;
        enable = 1'b1;
        repeat (LOCK_BUDGET - 1) @(posedge clk);
        @(negedge clk);
        chk("R8 no timeout at budget-1", int'(lock_timeout), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 timeout at budget", int'(lock_timeout), 1);
        chk("R7 no lock on constant ups", int'(lock), 0);
    endtask

    task automatic t_lock;
        enable = 1'b1;
        step(1'b1);
        chk_codes("R2 reinit", 0, 0, 0);
        step(1'b1); step(1'b1); step(1'b1);
        step(1'b0);
        step(1'b1);
        chk("R7 no lock after 3 alternating", int'(lock), 0);
        step(1'b0);
        chk("R7 lock after 4 alternating", int'(lock), 1);
        step(1'b1);
        chk("R7 lock held while alternating", int'(lock), 1);
        step(1'b1);
        chk("R7 lock drops on repeat", int'(lock), 0);
        chk_codes("R7 codes after dither", 0, 0, 4);
        repeat (LOCK_BUDGET + 50) @(negedge clk);
        chk("R8 no timeout after lock seen", int'(lock_timeout), 0);
    endtask

    task automatic t_high_saturation;
        int early_err;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        step(1'b1);
        early_err = 0;
        for (int n = 1; n <= 2031; n++) begin
            step(1'b1);
            if (range_err) early_err++;
        end
        chk("R6 no flag before top", early_err, 0);
        chk_codes("R6 top reached", 63, 63, 15);
        step(1'b1);
        chk("R6 high blocked flag", int'(range_err), 1);
        chk_codes("R6 high blocked codes", 63, 63, 15);
        step(1'b0);
        chk("R6 flag cleared by down", int'(range_err), 0);
        chk_codes("R5 down from top", 63, 63, 14);
    endtask

    initial begin
        t_reset;
        t_init_ignores_pd;
        t_low_saturation;
        t_tick_period;
        t_up_walk;
        t_down_walk;
        t_disable;
        t_timeout;
        t_disable;
        t_lock;
        t_high_saturation;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule